// File: doc/BRIEF.md
# Sticky Interrupt Pending and Mask Register Block

This block gathers up to sixteen interrupt request lines into one interrupt output. Each request line sets its own sticky pending bit. Because the bits are sticky, a request that lasts only one clock cycle is still held until software deals with it. A mask register picks which pending bits may drive the output. The output is high whenever at least one pending bit is also unmasked.

Software uses a small register bus with one-cycle write strobes and read strobes. It reads the pending bits and acknowledges them by writing ones to the bits it wants to clear. If a request arrives in the same cycle as the acknowledge of its bit, the request wins, so no interrupt is lost.

The two register offsets are parameters, so the same module can sit in different address maps without logic changes. A mask-update mode parameter chooses how mask writes behave: plain writes store the value, and toggle writes flip the bits written as one.

Top module: `irq_pend_ctrl`

## Requirements
- R1: On a synchronous reset, all pending bits and all mask bits clear to zero, `rdata` is zero and `irq_o` is low.
- R2: A source line seen high at a clock edge sets its pending bit (bit k for `src_i[k]`) at that edge. The bit stays set after the line drops, including for a one-cycle pulse.
- R3: A write to the status offset clears each pending bit whose `wdata` bit is 1. Pending bits whose `wdata` bit is 0 are unchanged.
- R4: If a source line is high at the same edge as an acknowledge write that clears its bit, the bit is still set after that edge.
- R5: With `MASK_MODE` = MASK_PLAIN, a write to the mask offset loads `wdata[NUM_SRC-1:0]` into the mask.
- R6: With `MASK_MODE` = MASK_XOR, a write to the mask offset flips each mask bit whose `wdata` bit is 1.
- R7: `irq_o` is high exactly when the bitwise AND of the pending bits and the mask bits is non-zero. It reflects the register state after each edge.
- R8: A read strobe at the status or mask offset returns that register, zero-extended, on `rdata` in the following cycle. The value is the one held before any write in the same cycle. In cycles that follow no read, `rdata` is zero.
- R9: Reads of any other offset return zero. Writes to any other offset change neither register.
- R10: After a pending bit is acknowledged, a later assertion of the same source sets it again and raises `irq_o` again if the bit is unmasked.
- R11: An instance with the status offset at 0x70, the mask offset at 0x74 and the toggle mode behaves as R2 to R9 describe at those offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Interrupt request lines, level or pulse |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register offset |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid the cycle after `rd_en` |
| irq_o | output | 1 | Aggregate interrupt, active high |

## Verification
The bench targets the collision where a source fires in the same edge as the acknowledge of its bit. A design that lets the clear win would lose that interrupt and read back zero. Acknowledge patterns that mix ones and zeros would expose a design that clears whole words or the wrong bits. Reads in the same cycle as a write would expose a read path that returns the post-write value. A second instance at other offsets with the toggle mode gets the same bus traffic. A decoder that ignored the offset parameters would change its registers on the other instance's writes, and a plain-write mask would show the wrong value after two toggles. Re-arming a bit after an acknowledge would catch a design whose pending bit stays cleared.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_STAT = 2'd1,
        SEL_MASK = 2'd2
    } reg_sel_e;

    typedef enum logic {
        MASK_PLAIN = 1'b0,
        MASK_XOR   = 1'b1
    } mask_mode_e;

    typedef struct packed {
        logic     wr;
        logic     rd;
        reg_sel_e sel;
    } bus_acc_t;

    // Status wins when both offsets are set equal.
    function automatic reg_sel_e decode_sel(input logic [31:0] a,
                                            input logic [31:0] stat_ofs,
                                            input logic [31:0] mask_ofs);
        if (a == stat_ofs)      return SEL_STAT;
        else if (a == mask_ofs) return SEL_MASK;
        else                    return SEL_NONE;
    endfunction

endpackage

// File: rtl/irq_pend_dec.sv
module irq_pend_dec
    import irq_pend_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter logic [ADDR_W-1:0] STAT_OFS = 'h00,
    parameter logic [ADDR_W-1:0] MASK_OFS = 'h10
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    output bus_acc_t          acc_o
);
    always_comb begin
        acc_o.wr  = wr_en;
        acc_o.rd  = rd_en;
        acc_o.sel = decode_sel(32'(addr), 32'(STAT_OFS), 32'(MASK_OFS));
    end
endmodule

// File: rtl/irq_pend_status.sv
module irq_pend_status #(
    parameter int unsigned NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] stat_o
);
    logic [NUM_SRC-1:0] stat_q;

    // Set is ORed in after the clear, so a new request always survives.
    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= (stat_q & ~clr_i) | src_i;
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/irq_pend_mask.sv
module irq_pend_mask
    import irq_pend_pkg::*;
#(
    parameter int unsigned NUM_SRC = 16,
    parameter mask_mode_e  MASK_MODE = MASK_PLAIN
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we_i,
    input  logic [NUM_SRC-1:0] wval_i,
    output logic [NUM_SRC-1:0] mask_o
);
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] mask_nx;

    generate
        if (MASK_MODE == MASK_XOR) begin : g_xor
            assign mask_nx = mask_q ^ wval_i;
        end else begin : g_plain
            assign mask_nx = wval_i;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)       mask_q <= '0;
        else if (we_i) mask_q <= mask_nx;
    end

    assign mask_o = mask_q;
endmodule

// File: rtl/irq_pend_rdport.sv
module irq_pend_rdport
    import irq_pend_pkg::*;
#(
    parameter int unsigned NUM_SRC = 16,
    parameter int unsigned DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  bus_acc_t           acc_i,
    input  logic [NUM_SRC-1:0] stat_i,
    input  logic [NUM_SRC-1:0] mask_i,
    output logic [DATA_W-1:0]  rdata_o
);
    logic [DATA_W-1:0] rd_sel;
    logic [DATA_W-1:0] rdata_q;

    always_comb begin
        unique case (acc_i.sel)
            SEL_STAT: rd_sel = DATA_W'(stat_i);
            SEL_MASK: rd_sel = DATA_W'(mask_i);
            default:  rd_sel = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)           rdata_q <= '0;
        else if (acc_i.rd) rdata_q <= rd_sel;
        else               rdata_q <= '0;
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
    import irq_pend_pkg::*;
#(
    parameter int unsigned NUM_SRC = 16,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = 32,
    parameter logic [ADDR_W-1:0] STAT_OFS = 'h00,
    parameter logic [ADDR_W-1:0] MASK_OFS = 'h10,
    parameter mask_mode_e  MASK_MODE = MASK_PLAIN
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               irq_o
);
    localparam int unsigned SRC_W = NUM_SRC;

    bus_acc_t         acc;
    logic [SRC_W-1:0] wbits;
    logic [SRC_W-1:0] clr_bits;
    logic             mask_we;
    logic [SRC_W-1:0] stat_q;
    logic [SRC_W-1:0] mask_q;

    irq_pend_dec #(
        .ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS), .MASK_OFS(MASK_OFS)
    ) u_dec (
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .acc_o(acc)
    );

    assign wbits    = wdata[SRC_W-1:0];
    assign clr_bits = (acc.wr && acc.sel == SEL_STAT) ? wbits : '0;
    assign mask_we  = acc.wr && acc.sel == SEL_MASK;

    irq_pend_status #(.NUM_SRC(SRC_W)) u_stat (
        .clk(clk), .rst(rst), .src_i(src_i), .clr_i(clr_bits), .stat_o(stat_q)
    );

    irq_pend_mask #(.NUM_SRC(SRC_W), .MASK_MODE(MASK_MODE)) u_mask (
        .clk(clk), .rst(rst), .we_i(mask_we), .wval_i(wbits), .mask_o(mask_q)
    );

    irq_pend_rdport #(.NUM_SRC(SRC_W), .DATA_W(DATA_W)) u_rd (
        .clk(clk), .rst(rst), .acc_i(acc), .stat_i(stat_q), .mask_i(mask_q),
        .rdata_o(rdata)
    );

    assign irq_o = |(stat_q & mask_q);
endmodule

// File: rtl/irq_pend_chk.sv
module irq_pend_chk #(
    parameter int unsigned NUM_SRC = 16,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = 32,
    parameter logic [ADDR_W-1:0] STAT_OFS = 'h00,
    parameter logic [ADDR_W-1:0] MASK_OFS = 'h10
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] src_i,
    input logic               wr_en,
    input logic               rd_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [DATA_W-1:0]  wdata,
    input logic [DATA_W-1:0]  rdata,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] stat,
    input logic [NUM_SRC-1:0] mask
);
    logic [NUM_SRC-1:0] clr_now;
    logic               unmapped_rd;
    logic               mask_wr;

    always_comb begin
        clr_now     = (wr_en && addr == STAT_OFS) ? wdata[NUM_SRC-1:0] : '0;
        unmapped_rd = rd_en && addr != STAT_OFS && addr != MASK_OFS;
        mask_wr     = wr_en && addr == MASK_OFS && addr != STAT_OFS;
    end

    p_irq_low_after_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> (!irq_o && rdata == '0));

    p_source_sets_pending_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat & $past(src_i)) == $past(src_i)));

    p_only_ack_clears_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(stat) & ~stat) & ~$past(clr_now)) == '0));

    p_mask_holds_r5: assert property (@(posedge clk) disable iff (rst)
        !mask_wr |=> $stable(mask));

    p_irq_needs_pending_r7: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (stat != '0 && mask != '0));

    p_unmapped_read_zero_r9: assert property (@(posedge clk) disable iff (rst)
        unmapped_rd |=> (rdata == '0));
endmodule

bind irq_pend_ctrl irq_pend_chk #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .STAT_OFS(STAT_OFS), .MASK_OFS(MASK_OFS)
) u_chk (
    .clk(clk), .rst(rst), .src_i(src_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o),
    .stat(stat_q), .mask(mask_q)
);

// File: tb/irq_pend_ctrl_tb_top.sv
module irq_pend_ctrl_tb_top;
    import irq_pend_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] src = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata_a, rdata_b;
    logic        irq_a, irq_b;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Bench-side register state, per instance
    logic [15:0] ms_a = '0, mm_a = '0, ms_b = '0, mm_b = '0;
    logic [31:0] q_a[$];
    logic [31:0] q_b[$];
    string       q_tag[$];
    logic        rd_seen = 1'b0;

    always #2 clk = ~clk;

    irq_pend_ctrl dut_i (
        .clk(clk), .rst(rst), .src_i(src), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata_a), .irq_o(irq_a)
    );

    irq_pend_ctrl #(
        .STAT_OFS(8'h70), .MASK_OFS(8'h74), .MASK_MODE(MASK_XOR)
    ) dut_alt_i (
        .clk(clk), .rst(rst), .src_i(src), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata_b), .irq_o(irq_b)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected read data one cycle after each read strobe
    always @(posedge clk) rd_seen <= rd_en;

    always @(negedge clk) begin
        if (rd_seen && q_a.size() > 0) begin
            logic [31:0] ea, eb;
            string t;
            ea = q_a.pop_front();
            eb = q_b.pop_front();
            t  = q_tag.pop_front();
            chk(rdata_a == ea, {t, " rdata main"}, rdata_a, ea);
            chk(rdata_b == eb, {t, " rdata alt"},  rdata_b, eb);
        end
    end

    function automatic logic [31:0] rd_val(input logic [7:0] a, input logic [7:0] so,
                                           input logic [7:0] mo, input logic [15:0] s,
                                           input logic [15:0] m);
        if (a == so)      return {16'h0, s};
        else if (a == mo) return {16'h0, m};
        else              return 32'h0;
    endfunction

    // Driver: one bus cycle, entered and left at a falling edge
    task automatic cyc(input logic [15:0] s, input bit w, input bit r,
                       input logic [7:0] a, input logic [31:0] d, input string tag);
        logic [15:0] clr_a, clr_b;
        src = s; wr_en = w; rd_en = r; addr = a; wdata = d;
        if (r) begin
            q_a.push_back(rd_val(a, 8'h00, 8'h10, ms_a, mm_a));
            q_b.push_back(rd_val(a, 8'h70, 8'h74, ms_b, mm_b));
            q_tag.push_back(tag);
        end
        @(posedge clk);
        clr_a = (w && a == 8'h00) ? d[15:0] : '0;
        clr_b = (w && a == 8'h70) ? d[15:0] : '0;
        ms_a = (ms_a & ~clr_a) | s;
        ms_b = (ms_b & ~clr_b) | s;
        if (w && a == 8'h10) mm_a = d[15:0];
        if (w && a == 8'h74) mm_b = mm_b ^ d[15:0];
        @(negedge clk);
        src = '0; wr_en = 1'b0; rd_en = 1'b0;
        chk(irq_a == |(ms_a & mm_a), {"R7 irq main after ", tag}, 32'(irq_a), 32'(|(ms_a & mm_a)));
        chk(irq_b == |(ms_b & mm_b), {"R7 irq alt after ", tag},  32'(irq_b), 32'(|(ms_b & mm_b)));
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        cyc('0, 1'b0, 1'b1, a, '0, tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
        cyc('0, 1'b1, 1'b0, a, d, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(rdata_a == 0 && rdata_b == 0, "R1 rdata after reset", rdata_a | rdata_b, 0);
        chk(!irq_a && !irq_b, "R1 irq after reset", 32'(irq_a | irq_b), 0);
        rd(8'h00, "R1 status main"); rd(8'h10, "R1 mask main");
        rd(8'h70, "R1 status alt");  rd(8'h74, "R1 mask alt");
        // R2: single-cycle pulse is latched and held
        cyc(16'h0008, 1'b0, 1'b0, 8'h00, 0, "R2 pulse bit3");
        cyc('0, 1'b0, 1'b0, 8'h00, 0, "R2 idle");
        rd(8'h00, "R2 status sticky main");
        rd(8'h70, "R2 R11 status sticky alt");
        // R5: plain mask write
        wr(8'h10, 32'hFFFF_0008, "R5 mask main");
        rd(8'h10, "R5 mask readback, R9 alt mask unchanged");
        rd(8'h74, "R9 R11 alt mask after foreign write");
        // R6: toggle mask on alt
        wr(8'h74, 32'h0000_000C, "R6 toggle 0xC");
        rd(8'h74, "R6 mask after first toggle");
        wr(8'h74, 32'h0000_0004, "R6 toggle 0x4");
        rd(8'h74, "R6 R11 mask after second toggle");
        // R3: acknowledge clears only bits written as one
        wr(8'h00, 32'h0000_0001, "R3 ack unset bit");
        rd(8'h00, "R3 status unchanged by zero bits");
        wr(8'h00, 32'h0000_0008, "R3 ack bit3");
        rd(8'h00, "R3 status cleared main");
        rd(8'h70, "R9 alt status untouched by foreign ack");
        wr(8'h70, 32'h0000_0008, "R3 R11 ack alt bit3");
        rd(8'h70, "R3 R11 status cleared alt");
        // R10: re-arm after acknowledge
        cyc(16'h0008, 1'b0, 1'b0, 8'h00, 0, "R10 re-pulse bit3");
        rd(8'h00, "R10 status re-set main");
        rd(8'h70, "R10 status re-set alt");
        // R4: source and acknowledge in the same edge
        cyc(16'h0020, 1'b0, 1'b0, 8'h00, 0, "R4 pre-set bit5");
        cyc(16'h0020, 1'b1, 1'b0, 8'h00, 32'h0000_0028, "R4 collide bit5 ack 3 and 5");
        rd(8'h00, "R4 bit5 kept, bit3 cleared");
        cyc(16'h0040, 1'b1, 1'b0, 8'h70, 32'h0000_0040, "R4 R11 collide alt bit6");
        rd(8'h70, "R4 R11 alt bit6 kept");
        // R8: read in the same cycle as a write returns the old value
        cyc('0, 1'b1, 1'b1, 8'h10, 32'h0000_A5A5, "R8 read during mask write");
        rd(8'h10, "R8 mask after write");
        cyc('0, 1'b1, 1'b1, 8'h00, 32'h0000_0020, "R8 read during ack");
        rd(8'h00, "R8 status after ack");
        // R9: unmapped read and write
        rd(8'h44, "R9 unmapped read");
        wr(8'h44, 32'hFFFF_FFFF, "R9 unmapped write");
        rd(8'h10, "R9 mask main after unmapped write");
        rd(8'h74, "R9 mask alt after unmapped write");
        // Wide patterns
        cyc(16'hFFFF, 1'b0, 1'b0, 8'h00, 0, "R2 all sources");
        wr(8'h00, 32'h0000_00FF, "R3 ack low byte");
        rd(8'h00, "R3 status after byte ack");
        wr(8'h74, 32'h0000_FFFF, "R6 invert alt mask");
        rd(8'h74, "R6 alt mask inverted");
        wr(8'h10, 32'h0000_0000, "R5 clear main mask");
        rd(8'h00, "R7 status with empty mask");
        wr(8'h70, 32'h0000_FFFF, "R3 ack all alt");
        rd(8'h70, "R3 alt fully cleared");
        cyc('0, 1'b0, 1'b0, 8'h00, 0, "R8 idle");
        chk(rdata_a == 0 && rdata_b == 0, "R8 rdata zero without read", rdata_a | rdata_b, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule